// File: doc/BRIEF.md
# Bounded Call-Depth Tracking Stack

This block is a debug aid that keeps a record of the subroutine entry points a processor is executing inside. Each entry holds the 16-bit target address of the entry and a tag giving the privilege mode that was active when the call was made. The instruction decoder drives a push strobe for calls, traps, exceptions and accepted interrupts. It drives a pop strobe for subroutine returns and returns from interrupt. Every stored slot is visible on flat read ports, each with its own valid bit, so a debugger can inspect the whole record at any time.

The physical storage has a fixed number of slots. The logical depth counter keeps running past that capacity. Calls nested deeper than the storage are counted but not recorded. When they return, the count comes back down without touching any stored entry, so the slots stay matched to their returns once the overflow unwinds. If the depth counter would wrap, the push is refused and a sticky fatal flag is raised.

Top module: `call_depth_stack`

## Requirements
- R1: After reset the depth is 0, every slot valid bit is 0, and the fatal flag and both result pulses are 0.
- R2: A push while depth < SLOTS writes the target address and mode tag (1 = user, 0 = supervisor) into slot index depth and sets that slot's valid bit. One cycle later, push_ok_o is high for exactly one cycle.
- R3: A push while the depth counter is below its maximum value raises the depth by exactly one, whether or not an entry is stored.
- R4: A push while depth >= SLOTS changes no slot, and push_ok_o stays low in the following cycle.
- R5: A pop lowers the depth by one, and a pop at depth 0 leaves it at 0.
- R6: After a pop's decrement, if the new depth is < SLOTS, the slot at that index is invalidated and pop_ok_o pulses for one cycle. Otherwise no slot changes and pop_ok_o stays low.
- R7: When push and pop are both high in one cycle, the block acts exactly as for a push alone.
- R8: A push while the depth counter holds its all-ones value leaves the depth and the slots unchanged and sets fatal_o. fatal_o then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request strobe |
| pop_i | input | 1 | Pop request strobe |
| tgt_addr_i | input | ADDR_W | Entry address recorded on push |
| user_mode_i | input | 1 | Mode at the call: 1 user, 0 supervisor |
| depth_o | output | CNT_W | Logical call depth |
| push_ok_o | output | 1 | Pulse: the last push stored an entry |
| pop_ok_o | output | 1 | Pulse: the last pop cleared a slot |
| fatal_o | output | 1 | Sticky depth-counter overflow flag |
| slot_addr_o | output | SLOTS*ADDR_W | Stored addresses, slot k at bits k*ADDR_W upward |
| slot_user_o | output | SLOTS | Mode tag per slot |
| slot_valid_o | output | SLOTS | Valid bit per slot |

## Verification
The assertions check the cycle-by-cycle rules on every cycle: push increments the depth, pop decrements with saturation, a full stack gives no success pulse, slots stay frozen during pops above capacity, and the fatal flag stays set. Only the bench's scenarios can show the stored content. It checks that the address and mode land in the right slot, that unwinding after an overflow clears exactly the slots that were written, that the same-cycle push/pop rule holds, and that the counter-wrap refusal is correct. The bench drives a small configuration through directed fills, drains, collisions and a long pseudo-random sweep against an arithmetic model of every slot.

// File: rtl/call_depth_stack.sv
module call_depth_stack #(
  parameter int SLOTS  = 10,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic [ADDR_W-1:0]        tgt_addr_i,
  input  logic                     user_mode_i,
  output logic [CNT_W-1:0]         depth_o,
  output logic                     push_ok_o,
  output logic                     pop_ok_o,
  output logic                     fatal_o,
  output logic [SLOTS*ADDR_W-1:0]  slot_addr_o,
  output logic [SLOTS-1:0]         slot_user_o,
  output logic [SLOTS-1:0]         slot_valid_o
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(SLOTS);
  localparam logic [CNT_W-1:0] MAXD = '1;

  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [SLOTS-1:0]  user_q, valid_q;
  logic [CNT_W-1:0]  depth_q, dec_depth;
  logic              pop_only;

  assign pop_only  = pop_i && !push_i;
  assign dec_depth = (depth_q == '0) ? '0 : depth_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q   <= '0;
      valid_q   <= '0;
      user_q    <= '0;
      push_ok_o <= 1'b0;
      pop_ok_o  <= 1'b0;
      fatal_o   <= 1'b0;
      for (int k = 0; k < SLOTS; k++) addr_q[k] <= '0;
    end else begin
      push_ok_o <= 1'b0;
      pop_ok_o  <= 1'b0;
      if (push_i) begin
        if (depth_q == MAXD) begin
          fatal_o <= 1'b1;
        end else begin
          depth_q <= depth_q + 1'b1;
          if (depth_q < CAP) begin
            addr_q[depth_q[IDX_W-1:0]]  <= tgt_addr_i;
            user_q[depth_q[IDX_W-1:0]]  <= user_mode_i;
            valid_q[depth_q[IDX_W-1:0]] <= 1'b1;
            push_ok_o <= 1'b1;
          end
        end
      end else if (pop_i) begin
        depth_q <= dec_depth;
        if (dec_depth < CAP) begin
          valid_q[dec_depth[IDX_W-1:0]] <= 1'b0;
          pop_ok_o <= 1'b1;
        end
      end
    end
  end

  assign depth_o      = depth_q;
  assign slot_user_o  = user_q;
  assign slot_valid_o = valid_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign slot_addr_o[g*ADDR_W +: ADDR_W] = addr_q[g];
  end

  a_r3_push_increments: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && depth_o != MAXD |=> depth_o == $past(depth_o) + 1'b1);
  a_r5_pop_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    pop_only |=> depth_o == (($past(depth_o) == '0) ? '0 : $past(depth_o) - 1'b1));
  a_r4_full_no_success: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && depth_o >= CAP |=> !push_ok_o && $stable(slot_valid_o));
  a_r6_deep_pop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pop_only && depth_o > CAP |=> !pop_ok_o && $stable(slot_valid_o));
  a_r7_no_dual_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_ok_o && pop_ok_o));
  a_r8_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |=> fatal_o);
  a_r8_wrap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && depth_o == MAXD |=> fatal_o && $stable(depth_o));
endmodule

// File: tb/sim_call_depth_stack.sv
`timescale 1ns/1ps
module sim_call_depth_stack;
  localparam int SLOTS = 4;
  localparam int AW    = 16;
  localparam int CW    = 6;
  localparam int MAXD  = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_i = 0, pop_i = 0, user_mode_i = 0;
  logic [AW-1:0] tgt_addr_i = '0;
  logic [CW-1:0] depth_o;
  logic push_ok_o, pop_ok_o, fatal_o;
  logic [SLOTS*AW-1:0] slot_addr_o;
  logic [SLOTS-1:0] slot_user_o, slot_valid_o;

  call_depth_stack #(.SLOTS(SLOTS), .ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .tgt_addr_i(tgt_addr_i), .user_mode_i(user_mode_i), .depth_o(depth_o),
    .push_ok_o(push_ok_o), .pop_ok_o(pop_ok_o), .fatal_o(fatal_o),
    .slot_addr_o(slot_addr_o), .slot_user_o(slot_user_o), .slot_valid_o(slot_valid_o));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string ph = "R1";
  int m_depth = 0;
  bit m_pok = 0, m_qok = 0, m_fatal = 0;
  logic [AW-1:0] m_addr [SLOTS];
  bit m_user [SLOTS];
  bit m_valid [SLOTS];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", req, ph, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3/R5 depth", int'(depth_o), m_depth);
    chk("R2/R4 push_ok", int'(push_ok_o), int'(m_pok));
    chk("R6 pop_ok", int'(pop_ok_o), int'(m_qok));
    chk("R8 fatal", int'(fatal_o), int'(m_fatal));
    for (int k = 0; k < SLOTS; k++) begin
      chk("R2/R6 valid", int'(slot_valid_o[k]), int'(m_valid[k]));
      if (m_valid[k]) begin
        chk("R2 addr", int'(slot_addr_o[k*AW +: AW]), int'(m_addr[k]));
        chk("R2 mode", int'(slot_user_o[k]), int'(m_user[k]));
      end
    end
  endtask

  task automatic op(bit p, bit q, logic [AW-1:0] a, bit u);
    @(negedge clk);
    check_all();
    push_i = p; pop_i = q; tgt_addr_i = a; user_mode_i = u;
    m_pok = 0; m_qok = 0;
    if (p) begin
      if (m_depth == MAXD) m_fatal = 1;
      else begin
        if (m_depth < SLOTS) begin
          m_addr[m_depth] = a; m_user[m_depth] = u; m_valid[m_depth] = 1; m_pok = 1;
        end
        m_depth++;
      end
    end else if (q) begin
      if (m_depth > 0) m_depth--;
      if (m_depth < SLOTS) begin m_valid[m_depth] = 0; m_qok = 1; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < SLOTS; k++) begin m_valid[k] = 0; m_user[k] = 0; m_addr[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ph = "R1";
    op(0, 0, '0, 0);
    ph = "R2 R3 R4 fill past capacity";
    for (int i = 0; i < SLOTS + 3; i++) op(1, 0, AW'(16'h1000 + i * 37), i[0]);
    ph = "R5 R6 drain below zero";
    for (int i = 0; i < SLOTS + 5; i++) op(0, 1, '0, 0);
    ph = "R7 simultaneous push and pop";
    for (int i = 0; i < SLOTS + 2; i++) op(1, 1, AW'(16'h2000 + i), ~i[0]);
    for (int i = 0; i < SLOTS + 2; i++) op(0, 1, '0, 0);
    ph = "R2 R6 pseudo-random sweep";
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op(lfsr[0] & (m_depth < 12 ? 1'b1 : lfsr[5]), lfsr[1], lfsr, lfsr[7]);
    end
    for (int i = 0; i < 20; i++) op(0, 1, '0, 0);
    ph = "R8 counter wrap";
    for (int i = 0; i < MAXD + 3; i++) op(1, 0, AW'(16'h3000 + i), 1'b0);
    for (int i = 0; i < MAXD + 2; i++) op(0, 1, '0, 0);
    op(0, 0, '0, 0);
    @(negedge clk);
    check_all();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule